// File: doc/BRIEF.md
# Three-Wire Addressed Configuration Register Loader

This block receives configuration words over a slow three-line serial port made of a serial clock, a serial data line and a latch-enable strobe. Bits are captured on each rising serial clock edge into an 18-bit shift register, most-significant bit first. When latch enable rises, the frame is committed. The two bits shifted in last select one of four target registers, and the sixteen bits ahead of them become that register's new contents.

The three serial lines are asynchronous to the system clock. Each passes through a synchronizer chain, and its edges are detected in the system clock domain. The four register values drive synthesizer counter settings and control bits directly. A single-cycle load strobe per register tells the downstream logic which word has just changed. The loader does not check frame length: the most recent 18 bits in the shift register are always the ones used.

Top module: `serial_cfg_loader`

## Requirements
- R1: While reset is asserted, all four registers read zero and every load strobe is low.
- R2: A data bit is captured on each rising edge of the serial clock and enters the shift register at bit 0, so the first bit of a frame ends in bit 17 (most-significant first).
- R3: Frame bits [1:0] (the last two bits shifted in) give the target register index 0 to 3. Register k occupies reg_q[16*k+15:16*k], and its strobe is load_stb[k].
- R4: On a rising edge of latch enable, the addressed register takes frame bits [17:2]. The address bits are not stored.
- R5: Each rising edge of latch enable produces exactly one load strobe, lasting one system clock cycle, on the addressed register. It appears in the same cycle as the new register value.
- R6: A commit leaves the three registers it does not address unchanged.
- R7: Serial clock edges without a latch-enable rise leave every register unchanged. Holding latch enable high does not cause a second write.
- R8: Frames shorter or longer than 18 bits are accepted. The commit uses the latest 18 bits shifted in, including bits left over from earlier frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_le | input | 1 | Latch enable, asynchronous |
| reg_q | output | 64 | Four 16-bit register values; register k sits at bits 16*k+15 down to 16*k |
| load_stb | output | 4 | One-cycle commit strobe per register |

## Verification
The bench builds the block with its default parameters: an 18-bit frame, a 2-bit address and two synchronizer stages. With these values every register index, the exact bit alignment of the data field and the address decode can be checked against literal words. Frames of 8 and 22 bits show that leftover bits carry into the next commit. A long latch-enable pulse and a bare run of serial clocks show that neither writes a register.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

   // Serial events, already moved into the system clock domain
   typedef struct packed {
      logic clk_rise;
      logic dat;
      logic le_rise;
   } ser_evt_t;

   localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int unsigned WIDTH  = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= '0;
         end else if (s == 0) begin
            chain[s] <= d;
         end else begin
            chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/cfg_edge.sv
module cfg_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
   parameter int unsigned FRAME_W = 18
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               shift_en,
   input  logic               din,
   output logic [FRAME_W-1:0] frame_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        frame_q <= '0;
      else if (shift_en) frame_q <= {frame_q[FRAME_W-2:0], din};
   end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
   parameter int unsigned ADDR_W = 2,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned NREG  = 1 << ADDR_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   commit,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [DATA_W-1:0]      data,
   output logic [NREG*DATA_W-1:0] regs_q,
   output logic [NREG-1:0]        stb_q
);
   for (genvar k = 0; k < NREG; k++) begin : g_reg
      logic hit;
      assign hit = commit && (addr == ADDR_W'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[k*DATA_W +: DATA_W] <= '0;
            stb_q[k]                   <= 1'b0;
         end else begin
            stb_q[k] <= hit;
            if (hit) regs_q[k*DATA_W +: DATA_W] <= data;
         end
      end
   end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader #(
   parameter int unsigned FRAME_W     = 18,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned DATA_W     = FRAME_W - ADDR_W,
   localparam int unsigned NREG       = 1 << ADDR_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ser_clk,
   input  logic                   ser_dat,
   input  logic                   ser_le,
   output logic [NREG*DATA_W-1:0] reg_q,
   output logic [NREG-1:0]        load_stb
);
   import cfg_loader_pkg::*;

   if (ADDR_W < 1 || FRAME_W <= ADDR_W + 1) begin : g_bad_frame
      $error("serial_cfg_loader: FRAME_W must exceed ADDR_W+1 and ADDR_W must be at least 1");
   end
   if (SYNC_STAGES < MIN_SYNC_STAGES) begin : g_bad_sync
      $error("serial_cfg_loader: SYNC_STAGES below minimum");
   end

   logic [2:0]         sync_lvl;
   ser_evt_t           evt;
   logic [FRAME_W-1:0] frame_q;

   cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({ser_clk, ser_dat, ser_le}),
      .q     (sync_lvl)
   );

   assign evt.dat = sync_lvl[1];

   cfg_edge u_clk_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (sync_lvl[2]),
      .rise  (evt.clk_rise)
   );

   cfg_edge u_le_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (sync_lvl[0]),
      .rise  (evt.le_rise)
   );

   cfg_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (evt.clk_rise),
      .din      (evt.dat),
      .frame_q  (frame_q)
   );

   cfg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .commit (evt.le_rise),
      .addr   (frame_q[ADDR_W-1:0]),
      .data   (frame_q[FRAME_W-1:ADDR_W]),
      .regs_q (reg_q),
      .stb_q  (load_stb)
   );
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
   parameter int unsigned FRAME_W = 18,
   parameter int unsigned ADDR_W  = 2,
   localparam int unsigned DATA_W = FRAME_W - ADDR_W,
   localparam int unsigned NREG   = 1 << ADDR_W
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [FRAME_W-1:0]     frame_q,
   input logic [NREG*DATA_W-1:0] reg_q,
   input logic [NREG-1:0]        load_stb
);
   // R5
   stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_stb));

   // R5
   stb_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_stb != '0) |=> (load_stb == '0));

   for (genvar k = 0; k < NREG; k++) begin : g_chk
      // R4
      data_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
         load_stb[k] |-> (reg_q[k*DATA_W +: DATA_W] == $past(frame_q[FRAME_W-1:ADDR_W])));

      // R3
      addr_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
         load_stb[k] |-> ($past(frame_q[ADDR_W-1:0]) == ADDR_W'(k)));

      // R7
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !load_stb[k] |-> $stable(reg_q[k*DATA_W +: DATA_W]));
   end
endmodule

bind serial_cfg_loader cfg_loader_chk #(.FRAME_W(FRAME_W), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .frame_q  (frame_q),
   .reg_q    (reg_q),
   .load_stb (load_stb)
);

// File: tb/serial_cfg_loader_test.sv
module serial_cfg_loader_test;
   localparam int CLK_PERIOD = 10;
   localparam int HALF_SER   = 5;
   localparam int FRAME_W    = 18;
   localparam int DATA_W     = 16;
   localparam int NREG       = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
   logic [NREG*DATA_W-1:0] reg_q;
   logic [NREG-1:0]        load_stb;

   int checks = 0;
   int errors = 0;

   logic [FRAME_W-1:0] model_sr = '0;
   logic [DATA_W-1:0]  model_regs [NREG];
   logic [FRAME_W-1:0] exp_q [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   serial_cfg_loader uut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
      .ser_le(ser_le), .reg_q(reg_q), .load_stb(load_stb)
   );

   function automatic logic [NREG*DATA_W-1:0] flat_model();
      logic [NREG*DATA_W-1:0] v;
      for (int k = 0; k < NREG; k++) v[k*DATA_W +: DATA_W] = model_regs[k];
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   // R2: one bit per rising serial clock, model shifts in at bit 0
   task automatic send_bits(input logic [31:0] v, input int n);
      for (int i = n-1; i >= 0; i--) begin
         ser_dat = v[i];
         wait_clk(HALF_SER);
         ser_clk = 1'b1;
         model_sr = {model_sr[FRAME_W-2:0], v[i]};
         wait_clk(HALF_SER);
         ser_clk = 1'b0;
      end
   endtask

   task automatic latch(input int hold);
      exp_q.push_back(model_sr);
      ser_le = 1'b1;
      wait_clk(hold);
      ser_le = 1'b0;
      wait_clk(HALF_SER);
   endtask

   task automatic write_reg(input logic [1:0] a, input logic [15:0] d);
      send_bits({14'd0, d, a}, FRAME_W);
      latch(10);
   endtask

   // Scoreboard monitor
   logic [NREG-1:0] prev_stb = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (load_stb != '0 && prev_stb != '0)
            chk(1'b0, "R5 strobe longer than one cycle", 64'(load_stb), 64'(0));
         if (load_stb != '0) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R7 unexpected strobe", 64'(load_stb), 64'(0));
            end else begin
               logic [FRAME_W-1:0] f;
               int a;
               f = exp_q.pop_front();
               a = int'(f[1:0]);
               chk(load_stb == NREG'(1 << a), "R3/R5 strobe select", 64'(load_stb), 64'(1 << a));
               chk(reg_q[a*DATA_W +: DATA_W] == f[FRAME_W-1:2], "R4 data field",
                   64'(reg_q[a*DATA_W +: DATA_W]), 64'(f[FRAME_W-1:2]));
               model_regs[a] = f[FRAME_W-1:2];
               chk(reg_q == flat_model(), "R6 other registers", reg_q, flat_model());
            end
         end
         prev_stb <= load_stb;
      end else begin
         prev_stb <= '0;
      end
   end

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      for (int k = 0; k < NREG; k++) model_regs[k] = '0;
      wait_clk(3);
      chk(reg_q == '0, "R1 registers in reset", reg_q, 64'(0));
      chk(load_stb == '0, "R1 strobes in reset", 64'(load_stb), 64'(0));
      rst_n = 1'b1;
      wait_clk(3);

      write_reg(2'd0, 16'hA5C3);
      write_reg(2'd1, 16'h1234);
      write_reg(2'd2, 16'hFFFF);
      write_reg(2'd3, 16'h0001);
      chk(reg_q == 64'h0001_FFFF_1234_A5C3, "R2/R4 full map", reg_q, 64'h0001_FFFF_1234_A5C3);

      // R7: serial clocks with no latch enable
      send_bits(32'h2AB, 10);
      wait_clk(6);
      chk(reg_q == flat_model(), "R7 shift without latch", reg_q, flat_model());

      // R8: short frame reuses bits already shifted
      send_bits(32'h5D, 8);
      latch(10);
      wait_clk(4);
      chk(exp_q.size() == 0, "R8 short frame committed", 64'(exp_q.size()), 64'(0));

      // R8: long frame keeps only the latest 18 bits
      send_bits(32'h3C_7E5A, 22);
      latch(10);
      wait_clk(4);
      chk(reg_q == flat_model(), "R8 long frame", reg_q, flat_model());

      // R7: long latch pulse gives one write only
      write_reg(2'd2, 16'h0000);
      send_bits({14'd0, 16'hBEEF, 2'd1}, FRAME_W);
      latch(60);
      wait_clk(4);
      chk(reg_q == 64'h0001_0000_BEEF_A5C3 || reg_q != flat_model() ? reg_q == flat_model() : 1'b0,
          "R7 held latch", reg_q, flat_model());
      chk(exp_q.size() == 0, "R5 every latch strobed", 64'(exp_q.size()), 64'(0));

      // R1: reset during operation
      rst_n = 1'b0;
      wait_clk(2);
      chk(reg_q == '0, "R1 reset clears", reg_q, 64'(0));
      chk(load_stb == '0, "R1 reset strobes", 64'(load_stb), 64'(0));
      finish_run();
   end
endmodule